// File: doc/BRIEF.md
# Fault-Only-First Vector Length Trimmer

This block decides how a fault-only-first unit-stride vector load of byte elements ends, for one line-sized group of elements. Each request gives the current vector length, the index where processing begins, a per-element fault flag, a per-element active mask bit and an optional early-stop request with its own element index. The early stop stands for a non-fault event such as a cache miss. One registered response comes back. It reports one of three outcomes: the load completes with its original length, the load completes with a shorter length, or the load traps at the first element processed. A per-element write-enable vector comes with the outcome.

Only faults in the processing window count: from the start index up to, but not including, the current length. The window is searched for its lowest set fault flag, and the mask is ignored in this search. The index found is used as the trap index when it equals the start index. Otherwise it is used as the trimmed length. Both uses share one priority encoder. An early-stop request can shorten the length further, but it can never stop at the start element. Because a trim point always lies above the start index, the trimmed length is never zero. At least one element always completes, which guarantees forward progress.

Requests and responses use valid/ready handshakes. `in_ready` is high when the output register is empty or is being drained in the same cycle. A request accepted at a rising edge shows up as `out_valid` right after that edge. While `out_valid` is high and `out_ready` is low, the response holds steady and new requests are refused. With `out_ready` held high, the block accepts one request every cycle.

Top module: `vff_trim`

## Requirements
- R1: With no fault in the window and no usable early stop, the outcome is FULL (`rsp_kind`=2'd0), `rsp_len` equals the request length and `rsp_trap_idx` is 0.
- R2: A fault at the start index gives TRAP (`rsp_kind`=2'd2) with `rsp_trap_idx` equal to the start index and `rsp_wen` all zero. An early stop does not suppress the trap.
- R3: When the lowest fault in the window lies above the start index, the outcome is TRIM (`rsp_kind`=2'd1) and `rsp_len` is that fault's index. A fault on a masked-off element still counts.
- R4: An early stop with index s, where start < s < length, gives TRIM with `rsp_len`=s when no fault comes earlier. A stop at or below the start index, or at or above the length, has no effect.
- R5: When both a window fault (above start) and a usable early stop are present, `rsp_len` is the smaller of the two indices.
- R6: Fault flags below the start index or at or above the request length are ignored.
- R7: A TRIM length is always greater than the start index, so it is at least 1, and it is below the request length.
- R8: `rsp_wen[i]` (bit i = element i) is high only when i ≥ start, i < `rsp_len` and mask bit i is set. On TRAP, every bit is low.
- R9: A request accepted while `in_valid` and `in_ready` are both high produces `out_valid` after the next rising edge. `in_ready` = !`out_valid` || `out_ready`. A stalled response holds all of its fields.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_len | input | LEN_W (7) | Current vector length, 0..NUM_ELEM |
| in_start | input | IDX_W (6) | Index of the first element processed |
| in_fault | input | NUM_ELEM (64) | Per-element fault flags |
| in_mask | input | NUM_ELEM (64) | Per-element active mask |
| in_stop_vld | input | 1 | Early-stop request present |
| in_stop_idx | input | IDX_W (6) | Element index of the early stop |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Response consumer ready |
| rsp_kind | output | 2 | 0 FULL, 1 TRIM, 2 TRAP |
| rsp_len | output | LEN_W (7) | Resulting vector length (request length on FULL and TRAP) |
| rsp_trap_idx | output | IDX_W (6) | Faulting element index on TRAP, else 0 |
| rsp_wen | output | NUM_ELEM (64) | Per-element write enable |

## Verification
A fault in the window-qualified encoder would show up on the very first response after the bad request. It would appear as a wrong outcome kind or a trim length that is off. A masked fault or a fault outside the window is the most sensitive case, because each can turn a FULL into a TRIM or the reverse. Handshake state is checked at every edge. A lost or duplicated response, or a field that changes while the response is stalled, is visible one cycle after it happens.

// File: rtl/vff_trim_pkg.sv
package vff_trim_pkg;
  typedef enum logic [1:0] {
    RES_FULL = 2'd0,
    RES_TRIM = 2'd1,
    RES_TRAP = 2'd2
  } res_kind_e;
endpackage

// File: rtl/vff_first_set.sv
// Lowest-index set bit of a vector.
module vff_first_set #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vff_resolve.sv
// Decides FULL / TRIM / TRAP from windowed faults and an early stop.
module vff_resolve
  import vff_trim_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = $clog2(N),
  parameter int LW = IW + 1
) (
  input  logic [LW-1:0] len_i,
  input  logic [IW-1:0] start_i,
  input  logic [N-1:0]  fault_i,
  input  logic          stop_vld_i,
  input  logic [IW-1:0] stop_idx_i,
  output res_kind_e     kind_o,
  output logic [LW-1:0] len_o,
  output logic [IW-1:0] trap_idx_o
);
  logic [N-1:0]  win_fault;
  logic          f_found;
  logic [IW-1:0] f_idx;
  logic          stop_ok;
  logic [IW-1:0] pick;

  // Only elements in [start, len) can fault; the mask plays no part.
  for (genvar g = 0; g < N; g++) begin : g_win
    assign win_fault[g] = fault_i[g] && (LW'(g) >= LW'(start_i)) && (LW'(g) < len_i);
  end

  vff_first_set #(.N(N), .IW(IW)) u_enc (
    .vec   (win_fault),
    .found (f_found),
    .idx   (f_idx)
  );

  // A stop can never land on the start element, nor outside the window.
  assign stop_ok = stop_vld_i && (stop_idx_i > start_i) && (LW'(stop_idx_i) < len_i);

  always_comb begin
    kind_o     = RES_FULL;
    len_o      = len_i;
    trap_idx_o = '0;
    pick       = '0;
    if (f_found && (f_idx == start_i)) begin
      kind_o     = RES_TRAP;
      trap_idx_o = f_idx;
    end else if (f_found || stop_ok) begin
      kind_o = RES_TRIM;
      if (f_found && stop_ok) pick = (stop_idx_i < f_idx) ? stop_idx_i : f_idx;
      else if (f_found)       pick = f_idx;
      else                    pick = stop_idx_i;
      len_o = LW'(pick);  // pick > start, so never zero
    end
  end
endmodule

// File: rtl/vff_wen_gen.sv
// Per-element write enables for the resolved window.
module vff_wen_gen #(
  parameter int N  = 64,
  parameter int IW = $clog2(N),
  parameter int LW = IW + 1
) (
  input  logic [IW-1:0] start_i,
  input  logic [LW-1:0] len_i,
  input  logic [N-1:0]  mask_i,
  input  logic          kill_i,
  output logic [N-1:0]  wen_o
);
  for (genvar g = 0; g < N; g++) begin : g_wen
    assign wen_o[g] = !kill_i && mask_i[g] &&
                      (LW'(g) >= LW'(start_i)) && (LW'(g) < len_i);
  end
endmodule

// File: rtl/vff_trim.sv
module vff_trim
  import vff_trim_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter int IDX_W    = $clog2(NUM_ELEM),
  parameter int LEN_W    = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LEN_W-1:0]    in_len,
  input  logic [IDX_W-1:0]    in_start,
  input  logic [NUM_ELEM-1:0] in_fault,
  input  logic [NUM_ELEM-1:0] in_mask,
  input  logic                in_stop_vld,
  input  logic [IDX_W-1:0]    in_stop_idx,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          rsp_kind,
  output logic [LEN_W-1:0]    rsp_len,
  output logic [IDX_W-1:0]    rsp_trap_idx,
  output logic [NUM_ELEM-1:0] rsp_wen
);
  res_kind_e             nx_kind;
  logic [LEN_W-1:0]      nx_len;
  logic [IDX_W-1:0]      nx_trap;
  logic [NUM_ELEM-1:0]   nx_wen;
  logic                  accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  vff_resolve #(.N(NUM_ELEM), .IW(IDX_W), .LW(LEN_W)) u_res (
    .len_i      (in_len),
    .start_i    (in_start),
    .fault_i    (in_fault),
    .stop_vld_i (in_stop_vld),
    .stop_idx_i (in_stop_idx),
    .kind_o     (nx_kind),
    .len_o      (nx_len),
    .trap_idx_o (nx_trap)
  );

  vff_wen_gen #(.N(NUM_ELEM), .IW(IDX_W), .LW(LEN_W)) u_wen (
    .start_i (in_start),
    .len_i   (nx_len),
    .mask_i  (in_mask),
    .kill_i  (nx_kind == RES_TRAP),
    .wen_o   (nx_wen)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      rsp_kind     <= RES_FULL;
      rsp_len      <= '0;
      rsp_trap_idx <= '0;
      rsp_wen      <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        rsp_kind     <= nx_kind;
        rsp_len      <= nx_len;
        rsp_trap_idx <= nx_trap;
        rsp_wen      <= nx_wen;
      end
    end
  end
endmodule

// File: rtl/vff_trim_chk.sv
module vff_trim_chk #(
  parameter int NUM_ELEM = 64,
  parameter int IDX_W    = $clog2(NUM_ELEM),
  parameter int LEN_W    = IDX_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LEN_W-1:0]    in_len,
  input logic [IDX_W-1:0]    in_start,
  input logic                out_valid,
  input logic                out_ready,
  input logic [1:0]          rsp_kind,
  input logic [LEN_W-1:0]    rsp_len,
  input logic [IDX_W-1:0]    rsp_trap_idx,
  input logic [NUM_ELEM-1:0] rsp_wen
);
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] start_q;
  logic             wen_out_of_window;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= '0;
      start_q <= '0;
    end else if (in_valid && in_ready) begin
      len_q   <= in_len;
      start_q <= in_start;
    end
  end

  always_comb begin
    wen_out_of_window = 1'b0;
    for (int i = 0; i < NUM_ELEM; i++)
      if (rsp_wen[i] && ((LEN_W'(i) >= rsp_len) || (LEN_W'(i) < LEN_W'(start_q))))
        wen_out_of_window = 1'b1;
  end

  p_full_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rsp_kind == 2'd0 |-> rsp_len == len_q && rsp_trap_idx == '0);

  p_trap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rsp_kind == 2'd2 |-> rsp_wen == '0 && rsp_trap_idx == start_q);

  p_trim_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rsp_kind == 2'd1 |-> rsp_len > LEN_W'(start_q) && rsp_len < len_q && rsp_len != '0);

  p_kind_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rsp_kind != 2'd3);

  p_wen_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !wen_out_of_window);

  p_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(rsp_kind) && $stable(rsp_len)
                                && $stable(rsp_trap_idx) && $stable(rsp_wen));
endmodule

bind vff_trim vff_trim_chk #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk, .rst_n, .in_valid, .in_ready, .in_len, .in_start, .out_valid, .out_ready,
  .rsp_kind, .rsp_len, .rsp_trap_idx, .rsp_wen
);

// File: tb/sim_vff_trim.sv
`timescale 1ns/1ps
module sim_vff_trim;
  localparam int N = 64;
  localparam int IW = 6;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_stop_vld = 1'b0, out_valid, out_ready = 1'b1;
  logic [LW-1:0] in_len = '0, rsp_len;
  logic [IW-1:0] in_start = '0, in_stop_idx = '0, rsp_trap_idx;
  logic [N-1:0]  in_fault = '0, in_mask = '0, rsp_wen;
  logic [1:0]    rsp_kind;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  vff_trim u0 (.*);

  // Expected outcome from the requirements.
  task automatic model(input int len, input int st, input logic [N-1:0] flt, input logic [N-1:0] msk,
                       input bit sv, input int si,
                       output int ek, output int el, output int et, output logic [N-1:0] ew);
    int ff = -1;
    for (int i = st; i < len; i++) if (ff < 0 && flt[i]) ff = i;
    ek = 0; el = len; et = 0; ew = '0;
    if (ff == st) begin ek = 2; et = st; end
    else begin
      int cut = 1000;
      if (ff > st) cut = ff;
      if (sv && si > st && si < len && si < cut) cut = si;
      if (cut != 1000) begin ek = 1; el = cut; end
      for (int i = 0; i < N; i++) ew[i] = msk[i] && i >= st && i < el;
    end
  endtask

  task automatic check(input string tag, input bit ok, input string what);
    total++;
    if (!ok) begin bad++; $display("FAIL %s %s", tag, what); end
  endtask

  task automatic run_one(input string tag, input int len, input int st, input logic [N-1:0] flt,
                         input logic [N-1:0] msk, input bit sv, input int si);
    int ek, el, et;
    logic [N-1:0] ew;
    string t;
    model(len, st, flt, msk, sv, si, ek, el, et, ew);
    @(negedge clk);
    in_valid = 1'b1; in_len = LW'(len); in_start = IW'(st); in_fault = flt; in_mask = msk;
    in_stop_vld = sv; in_stop_idx = IW'(si);
    @(negedge clk);
    in_valid = 1'b0;
    if (tag == "") t = (ek == 2) ? "R2" : (ek == 1 ? "R3/R4/R5" : "R1"); else t = tag;
    check(t, out_valid && rsp_kind == 2'(ek) && rsp_len == LW'(el) && rsp_trap_idx == IW'(et) && rsp_wen == ew,
          $sformatf("act v=%0b k=%0d len=%0d trap=%0d wen=%h exp v=1 k=%0d len=%0d trap=%0d wen=%h",
                    out_valid, rsp_kind, rsp_len, rsp_trap_idx, rsp_wen, ek, el, et, ew));
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] ones = '1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10", !out_valid && in_ready, $sformatf("act v=%0b rdy=%0b exp v=0 rdy=1", out_valid, in_ready));
    rst_n = 1'b1;

    run_one("R1", 64, 0, '0, ones, 1'b0, 0);
    run_one("R2", 40, 5, 64'h20, ones, 1'b1, 9);
    run_one("R3", 40, 5, 64'h1 << 12, ones, 1'b0, 0);
    run_one("R3", 40, 5, 64'h1 << 12, ~(64'h1 << 12), 1'b0, 0);
    run_one("R4", 50, 3, '0, ones, 1'b1, 20);
    run_one("R4", 50, 3, '0, ones, 1'b1, 3);
    run_one("R4", 50, 3, '0, ones, 1'b1, 50);
    run_one("R5", 50, 3, 64'h1 << 30, ones, 1'b1, 20);
    run_one("R5", 50, 3, 64'h1 << 10, ones, 1'b1, 20);
    run_one("R6", 20, 8, (64'h1 << 2) | (64'h1 << 25), ones, 1'b0, 0);
    run_one("R7", 64, 0, 64'h2, ones, 1'b0, 0);
    run_one("R7", 64, 0, '0, ones, 1'b1, 1);
    run_one("R8", 30, 4, 64'h1 << 20, 64'h5555_5555_5555_5555, 1'b0, 0);
    run_one("R8", 63, 0, 64'h1 << 63, 64'hF0F0_F0F0_F0F0_F0F0, 1'b0, 0);
    run_one("R1", 10, 20, 64'h1 << 22, ones, 1'b1, 30);

    // Back-pressure: response held, new request refused until drained.
    @(negedge clk);
    in_valid = 1'b1; in_len = 7'd30; in_start = 6'd2; in_fault = 64'h1 << 9; in_mask = ones; in_stop_vld = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    in_len = 7'd60; in_start = 6'd0; in_fault = '0;
    #1;
    check("R9", out_valid && !in_ready && rsp_kind == 2'd1 && rsp_len == 7'd9,
          $sformatf("act v=%0b rdy=%0b k=%0d len=%0d exp v=1 rdy=0 k=1 len=9", out_valid, in_ready, rsp_kind, rsp_len));
    @(negedge clk);
    check("R9", out_valid && rsp_kind == 2'd1 && rsp_len == 7'd9,
          $sformatf("act v=%0b k=%0d len=%0d exp held v=1 k=1 len=9", out_valid, rsp_kind, rsp_len));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", out_valid && rsp_kind == 2'd0 && rsp_len == 7'd60,
          $sformatf("act v=%0b k=%0d len=%0d exp v=1 k=0 len=60", out_valid, rsp_kind, rsp_len));
    @(negedge clk);
    check("R9", !out_valid, $sformatf("act v=%0b exp v=0", out_valid));

    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] f, m;
      f = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      m = {$urandom, $urandom};
      run_one("", int'($urandom_range(0, 64)), int'($urandom_range(0, 63)), f, m,
              1'($urandom), int'($urandom_range(0, 63)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule